// File: doc/BRIEF.md
# Recursive Parallel Incrementer

This block is a purely combinational incrementer for an unsigned word whose width is a power of two. A single enable bit chooses between passing the word through unchanged and producing the word plus one. The result is the sum word together with a carry-out. Taken together, these form a value one bit wider than the input.

The increment is built by repeated doubling. At the bottom level, every input bit is its own one-bit incrementer: the sum bit is the inverted input bit, and the carry is the input bit itself. At each higher level, two neighbouring blocks of equal size are merged, and both halves of the block have already been worked out in parallel.

- The lower half's sum passes through unchanged.
- The upper half takes its own incremented bits when the lower half carries out. Otherwise it keeps the original input bits.
- The merged carry is the AND of the two half carries.

Because of this structure, the depth of the logic grows with log2 of the width rather than with the width. A final selection driven by the enable turns the incrementer into a multi-bit half-adder.

Top module: `par_incr`

## Requirements
- R1: With `add_en`=1, the concatenation {`carry_out`, `sum_out`} equals `a_in`+1 as a W+1-bit unsigned value.
- R2: With `add_en`=0, `sum_out` equals `a_in` and `carry_out` is 0.
- R3: With `add_en`=1 and `a_in` all ones, `sum_out` is all zeros and `carry_out` is 1.
- R4: `carry_out` is 1 exactly when `add_en` is 1 and every bit of `a_in` is 1.
- R5: Bit 0 of `sum_out` equals bit 0 of `a_in` XOR `add_en`.
- R6: For every bit position i, `sum_out`[i] differs from `a_in`[i] exactly when `add_en` is 1 and all bits of `a_in` below position i are 1.
- R7: The parameter W may be any power of two from 1 upward, and R1 to R6 hold for W = 1, 2, 4 and 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | W | Unsigned operand word |
| add_en | input | 1 | 1 adds one to the operand, 0 passes the operand through |
| sum_out | output | W | Low W bits of the result |
| carry_out | output | 1 | Bit W of the result |

## Verification
The assertions re-evaluate four things against an independent arithmetic model every time the inputs change:

- the arithmetic relation to a+1 (R1);
- the pass-through behaviour (R2);
- the carry condition (R4);
- the per-bit flip rule (R6, which also gives R5).

The bench sweeps every operand value with both enable settings on four instances, of width 1, 2, 4 and 8. Only these scenarios show that the generated recursion is assembled correctly at each parameter value, including the degenerate single-bit instance and the all-ones wrap-around of R3.

// File: rtl/par_incr.sv
module par_incr #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic         add_en,
  output logic [W-1:0] sum_out,
  output logic         carry_out
);
  localparam int L = (W > 1) ? $clog2(W) : 0;

  initial begin
    if (W < 1 || (W & (W - 1)) != 0)
      $error("par_incr: W must be a power of two");
  end

  genvar l, j;
  for (l = 0; l <= L; l++) begin : g_lvl
    localparam int NB = W >> l;
    localparam int BS = 1 << l;
    logic [W-1:0]  p;
    logic [NB-1:0] c;
    if (l == 0) begin : g_leaf
      assign p = ~a_in;
      assign c = a_in;
    end else begin : g_merge
      localparam int H = BS / 2;
      for (j = 0; j < NB; j++) begin : g_blk
        localparam int B = j * BS;
        assign p[B +: H]     = g_lvl[l-1].p[B +: H];
        assign p[B + H +: H] = g_lvl[l-1].c[2*j] ? g_lvl[l-1].p[B + H +: H]
                                                 : a_in[B + H +: H];
        assign c[j]          = g_lvl[l-1].c[2*j] & g_lvl[l-1].c[2*j+1];
      end
    end
  end

  assign sum_out   = add_en ? g_lvl[L].p : a_in;
  assign carry_out = add_en & g_lvl[L].c[0];
endmodule

module par_incr_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] a_in,
  input logic         add_en,
  input logic [W-1:0] sum_out,
  input logic         carry_out
);
  logic [W:0] ref_val;
  logic       low_ones;

  assign ref_val = {1'b0, a_in} + {{W{1'b0}}, add_en};

  always_comb begin
    if (add_en)
      p_incr_r1: assert ({carry_out, sum_out} == ref_val)
        else $error("R1 violated");
    if (!add_en)
      p_pass_r2: assert (sum_out == a_in && !carry_out)
        else $error("R2 violated");
    p_carry_r4: assert (carry_out == (add_en && (&a_in)))
      else $error("R4 violated");
    p_lsb_r5: assert (sum_out[0] == (a_in[0] ^ add_en))
      else $error("R5 violated");
    low_ones = 1'b1;
    for (int i = 0; i < W; i++) begin
      p_flip_r6: assert ((sum_out[i] != a_in[i]) == (add_en && low_ones))
        else $error("R6 violated at bit %0d", i);
      low_ones = low_ones & a_in[i];
    end
  end
endmodule

bind par_incr par_incr_chk #(.W(W)) u_chk (
  .a_in(a_in),
  .add_en(add_en),
  .sum_out(sum_out),
  .carry_out(carry_out)
);

// File: tb/par_incr_tb.sv
module par_incr_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0] a8;
  logic       b;
  logic [0:0] s1; logic [1:0] s2; logic [3:0] s4; logic [7:0] s8;
  logic       c1, c2, c4, c8;

  par_incr #(.W(8)) u_dut (.a_in(a8),      .add_en(b), .sum_out(s8), .carry_out(c8));
  par_incr #(.W(1)) u_w1  (.a_in(a8[0:0]), .add_en(b), .sum_out(s1), .carry_out(c1));
  par_incr #(.W(2)) u_w2  (.a_in(a8[1:0]), .add_en(b), .sum_out(s2), .carry_out(c2));
  par_incr #(.W(4)) u_w4  (.a_in(a8[3:0]), .add_en(b), .sum_out(s4), .carry_out(c4));

  task automatic chk_width(int w, int s_got, bit c_got);
    int    mask  = (1 << w) - 1;
    int    av    = int'(a8) & mask;
    int    total = av + int'(b);
    int    s_exp = total & mask;
    bit    c_exp = (total >> w) & 1;
    string req;
    if (!b)                req = "R2";
    else if (av == mask)   req = "R3";
    else                   req = "R1";
    n_run++;
    if (s_got != s_exp || c_got != c_exp) begin
      n_fail++;
      $display("FAIL %s/R7 w=%0d a=%0d b=%0d: got sum=%0d carry=%0d, expected sum=%0d carry=%0d",
               req, w, av, b, s_got, c_got, s_exp, c_exp);
    end
    n_run++;
    if (c_got != (b && av == mask)) begin
      n_fail++;
      $display("FAIL R4 w=%0d a=%0d b=%0d: got carry=%0d expected %0d",
               w, av, b, c_got, (b && av == mask));
    end
    n_run++;
    if ((s_got & 1) != ((av & 1) ^ int'(b))) begin
      n_fail++;
      $display("FAIL R5 w=%0d a=%0d b=%0d: got lsb=%0d expected %0d",
               w, av, b, s_got & 1, (av & 1) ^ int'(b));
    end
    for (int i = 1; i < w; i++) begin
      bit lo  = ((av & ((1 << i) - 1)) == ((1 << i) - 1));
      bit flp = (((s_got ^ av) >> i) & 1) != 0;
      n_run++;
      if (flp != (b && lo)) begin
        n_fail++;
        $display("FAIL R6 w=%0d a=%0d b=%0d bit=%0d: got flip=%0d expected %0d",
                 w, av, b, i, flp, (b && lo));
      end
    end
  endtask

  initial begin
    a8 = '0;
    b  = 1'b0;
    @(negedge clk);
    n_run++;
    if (s8 != 8'd0 || c8 != 1'b0) begin
      n_fail++;
      $display("FAIL R2 idle: got sum=%0d carry=%0d expected sum=0 carry=0", s8, c8);
    end
    for (int bv = 0; bv < 2; bv++) begin
      for (int av = 0; av < 256; av++) begin
        @(posedge clk);
        a8 = av[7:0];
        b  = bv[0];
        @(negedge clk);
        chk_width(8, int'(s8), c8);
        if (av < 16) chk_width(4, int'(s4), c4);
        if (av < 4)  chk_width(2, int'(s2), c2);
        if (av < 2)  chk_width(1, int'(s1), c1);
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule